// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block gathers up to eight interrupt-source inputs behind one byte-wide host register. A host write loads the enable mask. A host read returns which sources have latched a pending interrupt. Each source goes through a synchronizer, and a rising edge then sets that source's pending latch, but only while its enable bit is set. A single request line is high whenever any pending latch is set.

The block has no separate acknowledge register. A handler reads the pending bits and writes the enable mask with those bits low, which clears them. If more sources fire during this, the handler repeats until the read returns zero. It then writes the full mask back to re-arm the sources, and this write does not bring back the old pending bits. Only sources in a parameterised valid mask are ever reported. An edge that lands in the same cycle as a write that clears its enable bit is lost.

Top module: `irq_src_reg`

## Requirements
- R1: After reset the enable mask and all pending bits are 0, `rd_data` reads 0 and `irq_o` is low.
- R2: A rising edge on a valid source whose enable bit is 1 sets that source's bit in `rd_data` (bit i for source i). The bit becomes visible on the third rising clock edge after the input goes high. A source held high sets nothing further.
- R3: A rising edge on a source whose enable bit is 0 leaves its pending bit clear. Setting the enable bit later does not make that edge appear.
- R4: A write (`wr_en` high for one clock) with bit i of `wr_data` at 0 clears pending bit i on that clock edge. Pending bits whose write bit is 1 keep their value.
- R5: An edge that would set pending bit i on the same clock edge as a write with bit i at 0 is dropped. So is an edge that coincides with the write setting that enable bit from 0, because the enable value held before the write decides.
- R6: While one source is being cleared by a write, an edge on another enabled source still sets its own pending bit.
- R7: Writing the enable mask back to all ones after pending bits were cleared does not restore those pending bits.
- R8: `rd_data` bits outside `VALID_MASK`, and bits at or above `NSRC`, always read 0. Edges on such sources never set a pending bit and never raise `irq_o`.
- R9: `irq_o` is high exactly when `rd_data` is nonzero.
- R10: A write of 0x00 clears every pending bit, and `irq_o` is low after that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Asynchronous interrupt-source inputs |
| wr_en | input | 1 | Host write strobe, loads the enable mask |
| wr_data | input | 8 | Host write data, bit i enables source i |
| rd_data | output | 8 | Pending bits masked by VALID_MASK |
| irq_o | output | 1 | Interrupt request, OR of the pending bits |

## Verification
The main function is tested with randomly toggling sources mixed with randomly timed mask writes. This separates edge-triggered capture from level-triggered capture, and it shows whether an edge is gated by the enable value before a write or after it. Directed sequences place an edge so it meets a clearing write in the same cycle, place an edge on a second source during a clear, and check a full-mask rewrite after a clear. These separate "clear drops the coincident edge" from "clear leaves other sources alone" and from "re-arm restores nothing". Edges on an invalid source are checked for any leak into the read data or the request line.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
   localparam int DATA_W = 8;
   typedef logic [DATA_W-1:0] host_byte_t;
endpackage

// File: rtl/irq_edge_sync.sv
// Per-source synchronizer chain followed by a rising-edge detector.
module irq_edge_sync #(
   parameter int NSRC   = 8,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] async_i,
   output logic [NSRC-1:0] rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_edge_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < NSRC; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            prev_q  <= chain_q[STAGES-1];
         end
      end

      assign rise_o[b] = chain_q[STAGES-1] & ~prev_q;
   end
endmodule

// File: rtl/irq_pend_bank.sv
// Enable mask and per-source pending latches.
module irq_pend_bank #(
   parameter int              NSRC  = 8,
   parameter logic [NSRC-1:0] VALID = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] rise_i,
   input  logic            wr_en,
   input  logic [NSRC-1:0] wr_bits,
   output logic [NSRC-1:0] en_o,
   output logic [NSRC-1:0] pend_o
);
   logic [NSRC-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= wr_bits & VALID;
   end

   for (genvar b = 0; b < NSRC; b++) begin : g_cell
      logic pend_q;
      logic kill;
      logic arm;

      assign kill = wr_en & ~wr_bits[b];
      assign arm  = rise_i[b] & en_q[b] & VALID[b];

      always_ff @(posedge clk) begin
         if (!rst_n)    pend_q <= 1'b0;
         else if (kill) pend_q <= 1'b0;
         else if (arm)  pend_q <= 1'b1;
      end

      assign pend_o[b] = pend_q;
   end

   assign en_o = en_q;
endmodule

// File: rtl/irq_src_reg.sv
module irq_src_reg
   import irq_src_pkg::*;
#(
   parameter int                NSRC        = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] VALID_MASK  = 8'hBF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);
   localparam logic [NSRC-1:0] VALID_N = VALID_MASK[NSRC-1:0];

   if (NSRC < 1 || NSRC > DATA_W) begin : g_bad_nsrc
      $error("irq_src_reg: NSRC must lie in 1..DATA_W");
   end

   logic [NSRC-1:0] rise;
   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] pend;

   irq_edge_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (src_i),
      .rise_o  (rise)
   );

   irq_pend_bank #(.NSRC(NSRC), .VALID(VALID_N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise),
      .wr_en   (wr_en),
      .wr_bits (wr_data[NSRC-1:0]),
      .en_o    (en_q),
      .pend_o  (pend)
   );

   if (NSRC == DATA_W) begin : g_full
      assign rd_data = pend & VALID_N;
   end else begin : g_pad
      assign rd_data = {{(DATA_W-NSRC){1'b0}}, pend & VALID_N};
   end

   assign irq_o = |pend;
endmodule

// File: rtl/irq_src_reg_chk.sv
module irq_src_reg_chk #(
   parameter int          NSRC       = 8,
   parameter int          DW         = 8,
   parameter logic [DW-1:0] VALID_MASK = '1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [DW-1:0]   wr_data,
   input logic [DW-1:0]   rd_data,
   input logic            irq_o,
   input logic [NSRC-1:0] en_q
);
   logic [DW-1:0] en_w;
   assign en_w = DW'(en_q);

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data == '0 && !irq_o));

   p_no_set_when_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(rst_n) |-> ((rd_data & ~$past(rd_data) & ~$past(en_w)) == '0));

   p_clear_on_low_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rd_data & ~$past(wr_data)) == '0));

   p_invalid_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~VALID_MASK) == '0);

   p_irq_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (rd_data != '0));

   p_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == '0) |=> !irq_o);
endmodule

bind irq_src_reg irq_src_reg_chk #(
   .NSRC(NSRC), .DW(irq_src_pkg::DATA_W), .VALID_MASK(VALID_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .irq_o(irq_o), .en_q(en_q)
);

// File: tb/irq_src_reg_bench.sv
module irq_src_reg_bench;
   localparam int         NSRC  = 8;
   localparam logic [7:0] VALID = 8'hBF;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] src;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_src_reg #(.NSRC(NSRC), .SYNC_STAGES(2), .VALID_MASK(VALID)) u_irq_src_reg (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
   );

   // Reference model built from R1..R10: two sync stages, edge stage, latch.
   logic [7:0] m_s1, m_s2, m_pv, m_en, m_pend;

   function automatic logic [7:0] next_pend(input logic [7:0] p, input logic [7:0] rise,
                                            input logic [7:0] en, input logic we,
                                            input logic [7:0] wd);
      logic [7:0] clr;
      clr = we ? ~wd : 8'h00;
      return (p & ~clr) | (rise & en & VALID & ~clr);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_en <= '0; m_pend <= '0;
      end else begin
         m_pend <= next_pend(m_pend, m_s2 & ~m_pv, m_en, wr_en, wr_data);
         m_s1 <= src; m_s2 <= m_s1; m_pv <= m_s2;
         if (wr_en) m_en <= wr_data & VALID;
      end
   end

   task automatic check(input string tag);
      checks++;
      if (rd_data !== (m_pend & VALID)) begin
         fails++;
         $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, m_pend & VALID);
      end
      checks++;
      if (irq_o !== (m_pend != 0)) begin
         fails++;
         $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, m_pend != 0);
      end
   endtask

   task automatic check_val(input string tag, input logic [7:0] exp);
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic host_wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; src = '0; wr_en = 1'b0; wr_data = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      check("R1"); check_val("R1", 8'h00);

      // R3: edge while disabled, then enable
      src = 8'h02; tick(4);
      check_val("R3", 8'h00);
      host_wr(8'h02); tick(2);
      check_val("R3", 8'h00); check("R3");
      src = 8'h00; tick(3);

      // R2: enabled edges latch; a held level does nothing more
      host_wr(8'h0F);
      src = 8'h0F; tick(2);
      check_val("R2", 8'h00);
      tick(1);
      check_val("R2", 8'h0F); check("R2");

      // R4: clear bits 0 and 1 only
      host_wr(8'h0C);
      check_val("R4", 8'h0C); check("R4");
      tick(3);
      check_val("R2", 8'h0C);

      // R7: rewrite full mask, nothing comes back
      host_wr(8'hFF);
      check_val("R7", 8'h0C); check("R7");

      // R10: zero write clears all
      host_wr(8'h00);
      check_val("R10", 8'h00); check("R10");
      src = 8'h00; tick(3);

      // R8: invalid source 6 never reported
      host_wr(8'hFF);
      src = 8'hC0; tick(4);
      check_val("R8", 8'h80); check("R8");

      // R6: clear bit 7 while bit 0 edge lands during the clear
      src = 8'hC1; tick(2);
      host_wr(8'h7F);
      check_val("R6", 8'h01); check("R6");
      host_wr(8'hFF);
      src = 8'h00; host_wr(8'h00); tick(3);

      // R5: edge coinciding with clearing write is dropped
      host_wr(8'hFF);
      src = 8'h02; tick(2);
      host_wr(8'hFD);
      check_val("R5", 8'h00); check("R5");
      tick(3);
      check_val("R5", 8'h00);
      src = 8'h00; tick(3);

      // R5: edge coinciding with an enabling write is dropped too
      host_wr(8'h00);
      src = 8'h04; tick(2);
      host_wr(8'h04);
      check_val("R5", 8'h00);
      src = 8'h00; tick(3);

      // Random phase: R2, R4, R9
      void'($urandom(32'd20240611));
      for (int c = 0; c < 3000; c++) begin
         if (($urandom % 3) == 0) src = src ^ 8'($urandom);
         wr_en   = (($urandom % 8) == 0);
         wr_data = 8'($urandom);
         tick(1);
         check("R9");
      end
      wr_en = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule